// File: doc/BRIEF.md
# Priority Flow-Control Request Sequencer

This block sits between user logic and a transmit pause-frame builder. The user raises per-queue XON or XOFF requests for up to eight priority queues, and optionally a link-wide legacy pause request. The legacy request can come from a pin or from a control register. The block detects each request on its rising edge and holds it as pending. It then hands a snapshot of all pending requests to the frame builder with a single-cycle send strobe, and waits for the builder's done acknowledgement.

When the acknowledgement arrives, the block reports on a status bus which requests went out in that frame. The status bus uses the same bit layout as the request vector. Requests that arrive while a frame is in flight are collected and sent together in the next frame. A queue whose XON and XOFF bits rise in the same cycle is cancelled rather than given a priority. A register-driven legacy pause command wins over a pin-driven one that rises in the same cycle.

Top module: `pfc_req_seq`

## Requirements
- R1: While reset is low and after its release with no requests, send_o, send_vec_o, send_pause_o, stat_valid_o, stat_vec_o and stat_pause_o are all zero.
- R2: A rising edge on pfc_req_i bit 2q (XON) or bit 2q+1 (XOFF) for queue q is captured. With the sequencer idle, send_o is high in the second cycle after the edge and send_vec_o carries that bit. Holding the level high does not trigger another send.
- R3: If both bits of a queue rise in the same cycle, that queue's pair contributes nothing. If no other request is pending, no send occurs.
- R4: A single-bit request for a queue that rises after an opposite request for the same queue is still pending replaces it, so the latest request wins.
- R5: send_o is a one-cycle pulse. send_vec_o and send_pause_o hold the frame contents unchanged until done_i is seen.
- R6: stat_valid_o is high only in the cycle where done_i is high while a frame is outstanding. In that cycle stat_vec_o and stat_pause_o equal exactly the bits of that frame; otherwise they are zero.
- R7: Requests that rise while a frame is outstanding are merged into the next frame. Its send_o pulse comes in the second cycle after the done cycle.
- R8: The legacy pause pair requests XON with pause_pin_i bit 0 and XOFF with bit 1. It is captured on rising edges and carried on send_pause_o and stat_pause_o with the same bit order.
- R9: If any bit of pause_reg_i rises in a cycle, the register pair is used for the legacy pause and a pin rise in that cycle is discarded.
- R10: done_i while no frame is outstanding has no effect: no status pulse and no send.
- R11: Both legacy pause bits rising together from one source are cancelled, as for a queue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pfc_req_i | input | 2*N_QUEUES | Per-queue requests, bit 2q XON, bit 2q+1 XOFF |
| pause_pin_i | input | 2 | Pin legacy pause: bit 0 XON, bit 1 XOFF |
| pause_reg_i | input | 2 | Register legacy pause, overrides the pin |
| done_i | input | 1 | Frame builder acknowledgement |
| send_o | output | 1 | One-cycle strobe starting a frame |
| send_vec_o | output | 2*N_QUEUES | Per-queue requests in the current frame |
| send_pause_o | output | 2 | Legacy pause request in the current frame |
| stat_valid_o | output | 1 | Qualifies the status buses |
| stat_vec_o | output | 2*N_QUEUES | Per-queue requests that were transmitted |
| stat_pause_o | output | 2 | Legacy pause request that was transmitted |

## Verification
A request edge presented before clock edge k is registered as pending at edge k and launched at edge k+1. The bench drives inputs on falling edges and samples send_o on the falling edge after k+1. The status pulse is combinational on done_i, so the bench samples it one time unit after raising done_i, in that same low phase. A merged frame launches one edge after the done edge, so the bench checks that send_o is still low after the done edge and high after the next one.

// File: rtl/pfc_pkg.sv
package pfc_pkg;
  typedef enum logic {ST_IDLE, ST_BUSY} seq_state_e;

  // exactly one of XON/XOFF: accepted; both together cancel
  function automatic logic pair_ok(input logic [1:0] p);
    return p[0] ^ p[1];
  endfunction
endpackage

// File: rtl/pfc_rise.sv
module pfc_rise #(
  parameter int W = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] rise_o
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= d_i;

  assign rise_o = d_i & ~prev_q;
endmodule

// File: rtl/pfc_pend.sv
module pfc_pend
  import pfc_pkg::*;
#(
  parameter int PAIRS = 4,
  localparam int W = 2 * PAIRS
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] rise_i,
  input  logic         clr_i,
  output logic [W-1:0] pend_o
);
  logic [W-1:0] pend_q;

  for (genvar q = 0; q < PAIRS; q++) begin : g_pair
    logic [1:0] base;
    assign base = clr_i ? 2'b00 : pend_q[2*q +: 2];

    always_ff @(posedge clk_i or negedge rst_ni)
      if (!rst_ni)                     pend_q[2*q +: 2] <= 2'b00;
      else if (pair_ok(rise_i[2*q +: 2])) pend_q[2*q +: 2] <= rise_i[2*q +: 2];
      else                             pend_q[2*q +: 2] <= base;

    AST_PAIR_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(pend_q[2*q] && pend_q[2*q+1])); // R3
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/pfc_seq.sv
module pfc_seq
  import pfc_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic any_pend_i,
  input  logic done_i,
  output logic launch_o,
  output logic busy_o,
  output logic ack_o,
  output logic send_o
);
  seq_state_e st_q;
  logic       send_q;

  assign busy_o   = (st_q == ST_BUSY);
  assign launch_o = (st_q == ST_IDLE) && any_pend_i;
  assign ack_o    = busy_o && done_i;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      send_q <= 1'b0;
    end else begin
      send_q <= launch_o;
      if (launch_o)   st_q <= ST_BUSY;
      else if (ack_o) st_q <= ST_IDLE;
    end

  assign send_o = send_q;

  AST_SEND_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    send_o |=> !send_o); // R5
endmodule

// File: rtl/pfc_req_seq.sv
module pfc_req_seq #(
  parameter int N_QUEUES = 4,
  localparam int W = 2 * N_QUEUES
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] pfc_req_i,
  input  logic [1:0]   pause_pin_i,
  input  logic [1:0]   pause_reg_i,
  input  logic         done_i,
  output logic         send_o,
  output logic [W-1:0] send_vec_o,
  output logic [1:0]   send_pause_o,
  output logic         stat_valid_o,
  output logic [W-1:0] stat_vec_o,
  output logic [1:0]   stat_pause_o
);
  logic [W-1:0] rise_req, pend_q;
  logic [1:0]   rise_pin, rise_reg, pause_sel, pend_p;
  logic         launch, busy, ack;
  logic [W-1:0] frame_vec_q;
  logic [1:0]   frame_pause_q;

  pfc_rise #(.W(W)) u_rise_req (.clk_i, .rst_ni, .d_i(pfc_req_i),   .rise_o(rise_req));
  pfc_rise #(.W(2)) u_rise_pin (.clk_i, .rst_ni, .d_i(pause_pin_i), .rise_o(rise_pin));
  pfc_rise #(.W(2)) u_rise_reg (.clk_i, .rst_ni, .d_i(pause_reg_i), .rise_o(rise_reg));

  // register command wins over pin in the same cycle
  assign pause_sel = (|rise_reg) ? rise_reg : rise_pin;

  pfc_pend #(.PAIRS(N_QUEUES)) u_pend_q (
    .clk_i, .rst_ni, .rise_i(rise_req), .clr_i(launch), .pend_o(pend_q));
  pfc_pend #(.PAIRS(1)) u_pend_p (
    .clk_i, .rst_ni, .rise_i(pause_sel), .clr_i(launch), .pend_o(pend_p));

  pfc_seq u_seq (
    .clk_i, .rst_ni,
    .any_pend_i(|{pend_q, pend_p}),
    .done_i,
    .launch_o(launch), .busy_o(busy), .ack_o(ack), .send_o);

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      frame_vec_q   <= '0;
      frame_pause_q <= '0;
    end else if (launch) begin
      frame_vec_q   <= pend_q;
      frame_pause_q <= pend_p;
    end

  assign send_vec_o   = frame_vec_q;
  assign send_pause_o = frame_pause_q;
  assign stat_valid_o = ack;
  assign stat_vec_o   = ack ? frame_vec_q   : '0;
  assign stat_pause_o = ack ? frame_pause_q : '0;

  AST_FRAME_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && $past(busy)) |-> ($stable(frame_vec_q) && $stable(frame_pause_q))); // R5
  AST_FRAME_NONEMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    send_o |-> (|{send_vec_o, send_pause_o})); // R2
  AST_STAT_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stat_valid_o |-> (stat_vec_o == '0 && stat_pause_o == '0)); // R6
endmodule

// File: tb/test_pfc_req_seq.sv
module test_pfc_req_seq;
  localparam int NQ = 4;
  localparam int W  = 2 * NQ;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic [W-1:0] pfc_req = '0;
  logic [1:0]   pin = '0, reg_p = '0;
  logic         done = 1'b0;
  logic         send_o, stat_valid_o;
  logic [W-1:0] send_vec_o, stat_vec_o;
  logic [1:0]   send_pause_o, stat_pause_o;
  int n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  pfc_req_seq #(.N_QUEUES(NQ)) i_pfc_req_seq (
    .clk_i(clk), .rst_ni, .pfc_req_i(pfc_req), .pause_pin_i(pin),
    .pause_reg_i(reg_p), .done_i(done), .send_o, .send_vec_o,
    .send_pause_o, .stat_valid_o, .stat_vec_o, .stat_pause_o);

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [W-1:0] expect_vec(input logic [W-1:0] p);
    logic [W-1:0] r = '0;
    for (int q = 0; q < NQ; q++)
      if (p[2*q] != p[2*q+1]) r[2*q +: 2] = p[2*q +: 2];
    return r;
  endfunction

  task automatic tick; @(negedge clk); endtask

  // acknowledge the outstanding frame, checking the status pulse
  task automatic ack_frame(input logic [W-1:0] ev, input logic [1:0] ep, input string tag);
    done = 1'b1; #1;
    chk(stat_valid_o === 1'b1, {tag, " R6 valid"}, stat_valid_o, 1);
    chk(stat_vec_o === ev, {tag, " R6 vec"}, stat_vec_o, ev);
    chk(stat_pause_o === ep, {tag, " R6 pause"}, stat_pause_o, ep);
    tick; done = 1'b0; #1;
    chk(stat_valid_o === 1'b0, {tag, " R6 one cycle"}, stat_valid_o, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog act=0 exp=1");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    tick; #1;
    chk(send_o === 0 && stat_valid_o === 0 && send_vec_o === 0 && send_pause_o === 0
        && stat_vec_o === 0 && stat_pause_o === 0, "R1 in reset", send_o, 0);
    tick; rst_ni = 1'b1; tick; tick;
    chk(send_o === 0 && send_vec_o === 0, "R1 after reset", send_vec_o, 0);

    // R2 R3: sweep every request pattern from idle
    for (int p = 0; p < (1 << W); p++) begin
      logic [W-1:0] ev;
      ev = expect_vec(p[W-1:0]);
      pfc_req = p[W-1:0];
      tick; tick;
      if (ev != 0) begin
        chk(send_o === 1'b1, "R2 send", send_o, 1);
        chk(send_vec_o === ev, "R2 vec", send_vec_o, ev);
        tick;
        chk(send_o === 1'b0, "R5 pulse", send_o, 0);
        chk(send_vec_o === ev, "R5 hold", send_vec_o, ev);
        tick; tick;
        chk(send_o === 1'b0, "R2 level no retrigger", send_o, 0);
        ack_frame(ev, 2'b00, "sweep");
      end else begin
        chk(send_o === 1'b0, "R3 cancel", send_o, 0);
        tick; tick;
        chk(send_o === 1'b0, "R3 cancel later", send_o, 0);
      end
      pfc_req = '0; tick; tick;
    end

    // R10: stray done while idle
    done = 1'b1; #1;
    chk(stat_valid_o === 1'b0, "R10 no status", stat_valid_o, 0);
    tick; done = 1'b0; tick; tick;
    chk(send_o === 1'b0, "R10 no send", send_o, 0);

    // R8: pin XOFF alone
    pin = 2'b10; tick; tick;
    chk(send_o === 1'b1 && send_pause_o === 2'b10, "R8 pin xoff", send_pause_o, 2);
    pin = 2'b00; tick;
    ack_frame('0, 2'b10, "R8");
    tick;

    // R11: both pin bits together
    pin = 2'b11; tick; tick; tick;
    chk(send_o === 1'b0 && send_pause_o === 2'b10, "R11 cancel", send_o, 0);
    pin = 2'b00; tick;

    // frame A: queue 0 XON
    pfc_req = 8'h01; tick; tick;
    chk(send_vec_o === 8'h01, "R2 frame A", send_vec_o, 1);
    pfc_req = '0; tick;
    // while busy: q1 XOFF, q2 XON then q2 XOFF, pin XON with reg XOFF
    pfc_req = 8'h18; pin = 2'b01; reg_p = 2'b10; tick;
    pfc_req = 8'h08; pin = 2'b00; reg_p = 2'b00; tick;
    pfc_req = 8'h28; tick;
    chk(send_vec_o === 8'h01, "R5 hold while merging", send_vec_o, 1);
    ack_frame(8'h01, 2'b00, "frame A");
    chk(send_o === 1'b0, "R7 not yet", send_o, 0);
    tick;
    chk(send_o === 1'b1, "R7 merged send", send_o, 1);
    chk(send_vec_o === 8'h28, "R4 R7 merged vec", send_vec_o, 8'h28);
    chk(send_pause_o === 2'b10, "R9 reg wins", send_pause_o, 2);
    pfc_req = '0; tick;
    ack_frame(8'h28, 2'b10, "frame B");
    tick; tick;
    chk(send_o === 1'b0, "R7 nothing left", send_o, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule